// File: doc/BRIEF.md
# Buffered Parallel-to-Serial Shifter

This block turns a parallel word into a serial bit stream through two stages. A capture stage holds a snapshot of the parallel input word. It is written only when its own strobe is raised. A shift chain of the same width can be loaded from that snapshot, cleared, or shifted one place per shift strobe. The shift chain takes a serial input at its low end and presents its top stage on the serial output. Because the snapshot is held apart from the shift chain, new input data can be captured while an earlier word is still being shifted out.

Everything runs on one clock. The capture and shift strobes act as clock enables, and the load and clear controls are sampled on every edge. Load has priority over shifting, and clear has priority over shifting. When load and clear are both asserted, the block sets the chain to zero and raises a flag for as long as that combination lasts. Several blocks can be chained by feeding one serial output into the next block's serial input.

Top module: `piso_buffered`

## Requirements
- R1: After the active-low global reset, both the capture stage and the shift chain hold all zeros, so serOut is 0 and a load followed by a full shift-out returns 0.
- R2: On an edge with storeEn high, the capture stage takes parIn. With storeEn low it holds its value, whatever shiftEn, loadN or clearN do.
- R3: On every edge with loadN low and clearN high, the shift chain copies the capture stage. This takes priority over shiftEn.
- R4: When loadN is low and storeEn is high on the same edge, the shift chain takes the new parIn value directly, in that same cycle.
- R5: On an edge with clearN low and loadN high, the shift chain becomes all zeros, whether or not shiftEn is set.
- R6: While loadN and clearN are both low, badCombo is 1 combinationally, and the chain is set to all zeros on each edge. In every other combination badCombo is 0.
- R7: On an edge with shiftEn high and both loadN and clearN high, stage n takes stage n-1 and stage 0 takes serIn. serOut always shows the top stage (bit WIDTH-1), so the word leaves the block MSB first.
- R8: Clear does not change the capture stage. A load issued after a clear returns the word captured before the clear.
- R9: When no strobe is set and loadN and clearN are both high, the shift chain holds its value, even if parIn and serIn change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Global reset, active low, synchronous |
| parIn | input | WIDTH | Parallel data word |
| storeEn | input | 1 | Capture strobe (clock enable for the capture stage) |
| shiftEn | input | 1 | Shift strobe (clock enable for the shift chain) |
| loadN | input | 1 | Load shift chain from capture stage, active low, level sensitive |
| clearN | input | 1 | Clear shift chain, active low |
| serIn | input | 1 | Serial input into stage 0 |
| serOut | output | 1 | Top stage of the shift chain |
| badCombo | output | 1 | High while load and clear are both asserted |

## Verification
The assertions take for granted that rstN is held low for at least one edge before any check counts, and that the inputs are stable around each rising edge. With that in place, each strobe decision can be compared with the register contents one cycle later. The stimulus changes every input on the falling edge, so each input is settled half a period before the edge that samples it. The double-low case on loadN and clearN is driven on purpose. It appears only in directed steps, where the flag and the zeroed chain are both checked.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef struct packed {
    logic doLoad;
    logic passThru;
    logic doClear;
    logic doShift;
  } strobe_t;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    storeEn,
  input  logic    shiftEn,
  input  logic    loadN,
  input  logic    clearN,
  output strobe_t strb,
  output logic    badCombo
);
  logic loadAct;
  logic clearAct;

  always_comb begin
    loadAct       = !loadN;
    clearAct      = !clearN;
    badCombo      = loadAct && clearAct;
    // clear wins in the double-low case (resolved to zeros)
    strb.doClear  = clearAct;
    strb.doLoad   = loadAct && !clearAct;
    strb.passThru = storeEn;
    strb.doShift  = shiftEn && !loadAct && !clearAct;
  end

  // R6: the flag must never coincide with a load decision
  p_flag_blocks_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    badCombo |-> (strb.doClear && !strb.doLoad));

  // R3/R5: shifting never occurs while either override is active
  p_shift_overridden_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN || !clearN) |-> !strb.doShift);
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             storeEn,
  input  logic             serIn,
  input  strobe_t          strb,
  output logic             serOut
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] capReg;
  logic [WIDTH-1:0] shReg;
  logic [WIDTH-1:0] shiftNext;
  logic [WIDTH-1:0] loadSrc;

  // capture stage
  always_ff @(posedge clk) begin
    if (!rstN)        capReg <= '0;
    else if (storeEn) capReg <= parIn;
  end

  // per-stage shift source
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        assign shiftNext[gi] = serIn;
      end else begin : g_rest
        assign shiftNext[gi] = shReg[gi-1];
      end
    end
  endgenerate

  assign loadSrc = strb.passThru ? parIn : capReg;

  always_ff @(posedge clk) begin
    if (!rstN)              shReg <= '0;
    else if (strb.doClear)  shReg <= '0;
    else if (strb.doLoad)   shReg <= loadSrc;
    else if (strb.doShift)  shReg <= shiftNext;
  end

  assign serOut = shReg[TOP];

  // R5/R6: a clear decision leaves zeros behind
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.doClear |=> (shReg == '0));

  // R3: load without pass-through copies the held snapshot
  p_load_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doLoad && !strb.passThru) |=> (shReg == $past(capReg)));

  // R4: load with a simultaneous capture takes the live word
  p_load_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doLoad && strb.passThru) |=> (shReg == $past(parIn)));

  // R7: one-place shift with serial entry at stage 0
  p_shift_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.doShift |=> (shReg == {$past(shReg[TOP-1:0]), $past(serIn)}));

  // R2/R8: the capture stage only changes under its strobe
  p_capture_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !storeEn |=> $stable(capReg));

  // R9: no decision, no change
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.doClear && !strb.doLoad && !strb.doShift) |=> $stable(shReg));
endmodule

// File: rtl/piso_buffered.sv
module piso_buffered
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             storeEn,
  input  logic             shiftEn,
  input  logic             loadN,
  input  logic             clearN,
  input  logic             serIn,
  output logic             serOut,
  output logic             badCombo
);
  strobe_t strb;

  piso_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .storeEn  (storeEn),
    .shiftEn  (shiftEn),
    .loadN    (loadN),
    .clearN   (clearN),
    .strb     (strb),
    .badCombo (badCombo)
  );

  piso_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .parIn   (parIn),
    .storeEn (storeEn),
    .serIn   (serIn),
    .strb    (strb),
    .serOut  (serOut)
  );

  // R6: after a double-low edge the output stage reads zero
  p_double_low_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    badCombo |=> (serOut == 1'b0));
endmodule

// File: tb/sim_piso_buffered.sv
module sim_piso_buffered;
  localparam int W = 8;
  localparam int NV = 6;
  localparam logic [W-1:0] VEC [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h81, 8'h3C, 8'h6E};

  logic clk = 1'b0;
  logic rstN, storeEn, shiftEn, loadN, clearN, serIn;
  logic [W-1:0] parIn;
  logic serOut, badCombo;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  piso_buffered #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .parIn(parIn), .storeEn(storeEn), .shiftEn(shiftEn),
    .loadN(loadN), .clearN(clearN), .serIn(serIn), .serOut(serOut), .badCombo(badCombo)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    storeEn = 0; shiftEn = 0; loadN = 1; clearN = 1; serIn = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // shifts the chain out MSB first; destroys contents
  task automatic readOut(output logic [W-1:0] word);
    idle();
    for (int i = W - 1; i >= 0; i--) begin
      word[i] = serOut;
      shiftEn = 1;
      step();
    end
    idle();
  endtask

  task automatic capture(input logic [W-1:0] d);
    idle(); parIn = d; storeEn = 1; step(); idle();
  endtask

  task automatic loadFromCap();
    idle(); loadN = 0; step(); idle();
  endtask

  initial begin
    #40000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got;
    idle(); parIn = '0; rstN = 0;
    @(negedge clk); step();
    rstN = 1;
    // R1: reset state
    check("R1 serOut", {7'd0, serOut}, 8'h00);
    check("R1 badCombo", {7'd0, badCombo}, 8'h00);
    loadFromCap(); readOut(got);
    check("R1 capture zero", got, 8'h00);

    // table: capture, load, shift out (R2, R3, R7)
    for (int v = 0; v < NV; v++) begin
      capture(VEC[v]);
      parIn = ~VEC[v];
      loadFromCap();
      readOut(got);
      check("R3/R7 table", got, VEC[v]);
    end

    // R2: capture ignores parIn without storeEn, even with shiftEn/clear
    capture(8'h5A);
    parIn = 8'hC3; shiftEn = 1; clearN = 0; step(); idle();
    loadFromCap(); readOut(got);
    check("R2 hold", got, 8'h5A);

    // R4: simultaneous load and capture passes new word through
    parIn = 8'h96; storeEn = 1; loadN = 0; step(); idle();
    parIn = 8'h00;
    readOut(got);
    check("R4 pass-through", got, 8'h96);
    loadFromCap(); readOut(got);
    check("R4 capture updated", got, 8'h96);

    // R3: load overrides shift
    capture(8'h3C);
    loadN = 0; shiftEn = 1; serIn = 1; step(); step(); idle();
    readOut(got);
    check("R3 override", got, 8'h3C);

    // R5 and R8: clear zeros chain even with shiftEn, capture kept
    capture(8'hFF); loadFromCap();
    check("R5 pre serOut", {7'd0, serOut}, 8'h01);
    clearN = 0; shiftEn = 1; serIn = 1; step(); idle();
    check("R5 serOut", {7'd0, serOut}, 8'h00);
    readOut(got);
    check("R5 cleared", got, 8'h00);
    loadFromCap(); readOut(got);
    check("R8 capture kept", got, 8'hFF);

    // R6: double low flag and zeroing
    capture(8'hE7); loadFromCap();
    loadN = 0; clearN = 1; #0;
    check("R6 flag load only", {7'd0, badCombo}, 8'h00);
    loadN = 1; clearN = 0; #1;
    check("R6 flag clear only", {7'd0, badCombo}, 8'h00);
    loadN = 0; clearN = 0; #0;
    check("R6 flag both", {7'd0, badCombo}, 8'h01);
    step();
    check("R6 flag held", {7'd0, badCombo}, 8'h01);
    idle();
    readOut(got);
    check("R6 zeroed", got, 8'h00);

    // R7: serial entry, MSB first
    idle();
    for (int i = W - 1; i >= 0; i--) begin
      logic [W-1:0] pat;
      pat = 8'hB2;
      serIn = pat[i]; shiftEn = 1; step();
    end
    idle();
    readOut(got);
    check("R7 serial in", got, 8'hB2);

    // R9: idle holds
    capture(8'h5A); loadFromCap();
    parIn = 8'hFF; serIn = 1;
    step(); step(); step();
    check("R9 serOut", {7'd0, serOut}, 8'h00);
    readOut(got);
    check("R9 hold", got, 8'h5A);

    done = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule